// File: doc/BRIEF.md
# Multi-Card Interrupt Source Arbiter

This block is one card's share of a shared interrupt scheme. Up to eight identical cards each serve eight serial channels. Each channel raises a request together with a 3-bit cause code. The card picks its highest-priority pending channel. A priority chain runs through the cards and lets the card nearest its head win over every card further down. The winning card answers the host's single read of the 16-bit arbitration word, which is located at I/O address 0x0130. That read returns the card number, the channel number and the cause code, so the host learns the source in one bus access.

The card also asserts one of eight interrupt request lines. The lines are shared and open-drain, and they idle high through an external pull-up. The card pulls the selected line low for as long as any of its channels has a request. The line is chosen by a setup register. The address decode sits outside this block and is reduced to a read strobe that marks the start of a read. The serial channels are reduced to request and cause inputs.

Top module: `irq_arb_card`

## Requirements
- R1: Among the pending channels, the lowest-numbered one wins, and its number appears in bits 2:0 of the read word.
- R2: Bits 8:6 of the read word carry the 3-bit cause code of the winning channel.
- R3: Bits 5:3 of the read word carry the card number given on `card_id`.
- R4: A word read from the winning card has bit 15 set to 1 and bits 14:9 set to 0.
- R5: `chain_out` is 1 whenever `chain_in` is 1 or any channel request on this card is 1. Otherwise it is 0.
- R6: The card drives a read (`rd_drive`=1) only when it has a pending request and `chain_in` is 0. In every other case, including when nothing is pending anywhere, `rd_drive` is 0 and `rd_data` is all zeros.
- R7: `rd_data` and `rd_drive` are captured on the clock edge at which `rd_start` is 1. They stay unchanged until the next such edge, whatever the requests do in between.
- R8: While any request is pending, exactly one bit of `irq_n` is 0, namely the bit at the index held in the line-select register. When no request is pending, all bits are 1, so the line is released once the host has cleared every channel.
- R9: The line-select register loads `cfg_line` on each clock edge at which `cfg_we` is 1.
- R10: After reset, `rd_data` is 0, `rd_drive` is 0 and the line-select register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_id | input | 3 | Strapped card number |
| chan_req | input | 8 | Per-channel interrupt request |
| chan_cause | input | 24 | Per-channel cause code, 3 bits each, channel n at bits 3n+2:3n |
| chain_in | input | 1 | A higher-priority card has a request pending |
| chain_out | output | 1 | This card or a card above it has a request pending |
| rd_start | input | 1 | One-cycle pulse at the start of a host read of the arbitration word |
| rd_data | output | 16 | Captured arbitration word (zero unless driving) |
| rd_drive | output | 1 | This card owns the read data bus |
| cfg_we | input | 1 | Write enable of the line-select register |
| cfg_line | input | 3 | New line-select value |
| irq_n | output | 8 | Open-drain request lines, 0 means pulled low |

## Verification
The assertions assume two things about the inputs. First, `chain_in` comes from a chain that is consistent with itself. Second, the host pulses `rd_start` for a single cycle. The hold property therefore treats every cycle without a pulse as one that must leave the captured word unchanged. The bench drives all inputs on the falling edge and keeps `rd_start` high for exactly one cycle per read. Between reads it changes requests and causes freely, so the hold rule is tested against real changes on the inputs. It never moves the line-select register except through `cfg_we`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int WORD_W    = 16;
  localparam int FIELD_W   = 3;
  localparam int PORT_LSB  = 0;
  localparam int CARD_LSB  = 3;
  localparam int CAUSE_LSB = 6;
  localparam int VALID_BIT = 15;

  // Builds the arbitration word from its three fields plus the valid flag.
  function automatic logic [WORD_W-1:0] pack_word(
      input logic [FIELD_W-1:0] card,
      input logic [FIELD_W-1:0] port,
      input logic [FIELD_W-1:0] cause);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PORT_LSB  +: FIELD_W] = port;
    w[CARD_LSB  +: FIELD_W] = card;
    w[CAUSE_LSB +: FIELD_W] = cause;
    w[VALID_BIT]            = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/irq_port_prio.sv
module irq_port_prio #(
  parameter int NUM_PORTS = 8,
  parameter int CAUSE_W   = 3,
  localparam int IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0]         req,
  input  logic [NUM_PORTS*CAUSE_W-1:0] cause,
  output logic                         any,
  output logic [IDX_W-1:0]             win_idx,
  output logic [CAUSE_W-1:0]           win_cause
);
  // Scan from the lowest priority upward so that the lowest index set is kept last.
  always_comb begin
    win_idx   = '0;
    win_cause = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (req[p]) begin
        win_idx   = IDX_W'(p);
        win_cause = cause[p*CAUSE_W +: CAUSE_W];
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_read_capture.sv
module irq_read_capture #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              grant,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else if (rd_start) begin
      rd_drive <= grant;
      rd_data  <= grant ? word_in : '0;
    end
  end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
  parameter int NUM_LINES = 8,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_line,
  input  logic                 pending,
  output logic [NUM_LINES-1:0] irq_n
);
  logic [SEL_W-1:0] line_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_sel <= '0;
    else if (cfg_we) line_sel <= cfg_line;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign irq_n[i] = !(pending && (line_sel == SEL_W'(i)));
  end
endmodule

// File: rtl/irq_arb_card.sv
module irq_arb_card
  import irq_arb_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 8,
  parameter int CAUSE_W   = FIELD_W,
  localparam int IDX_W    = $clog2(NUM_PORTS),
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [FIELD_W-1:0]           card_id,
  input  logic [NUM_PORTS-1:0]         chan_req,
  input  logic [NUM_PORTS*CAUSE_W-1:0] chan_cause,
  input  logic                         chain_in,
  output logic                         chain_out,
  input  logic                         rd_start,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_drive,
  input  logic                         cfg_we,
  input  logic [SEL_W-1:0]             cfg_line,
  output logic [NUM_LINES-1:0]         irq_n
);
  logic               local_any;
  logic [IDX_W-1:0]   win_idx;
  logic [CAUSE_W-1:0] win_cause;
  logic               grant;
  logic [WORD_W-1:0]  word_now;

  irq_port_prio #(.NUM_PORTS(NUM_PORTS), .CAUSE_W(CAUSE_W)) u_prio (
    .req(chan_req), .cause(chan_cause),
    .any(local_any), .win_idx(win_idx), .win_cause(win_cause)
  );

  // Daisy chain: a pending card blocks every card below it.
  assign chain_out = chain_in | local_any;
  assign grant     = local_any & ~chain_in;
  assign word_now  = pack_word(card_id, FIELD_W'(win_idx), FIELD_W'(win_cause));

  irq_read_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .grant(grant),
    .word_in(word_now), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  irq_line_drive #(.NUM_LINES(NUM_LINES)) u_line (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .pending(local_any), .irq_n(irq_n)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  chan_req,
  input logic        chain_in,
  input logic        chain_out,
  input logic        rd_start,
  input logic [15:0] rd_data,
  input logic        rd_drive,
  input logic [7:0]  irq_n
);
  p_chain_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_in |-> chain_out);
  p_chain_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_req) |-> chain_out);
  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && chain_in) |=> (!rd_drive && rd_data == 16'h0));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == 16'h0);
  p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (rd_data[15] && rd_data[14:9] == 6'h0));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> ($stable(rd_data) && $stable(rd_drive)));
  p_one_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_req) |-> $countones(~irq_n) == 1);
  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|chan_req) |-> irq_n == 8'hFF);
endmodule

bind irq_arb_card irq_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chain_in(chain_in),
  .chain_out(chain_out), .rd_start(rd_start), .rd_data(rd_data),
  .rd_drive(rd_drive), .irq_n(irq_n)
);

// File: tb/irq_arb_card_tb.sv
module irq_arb_card_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  card_id = '0;
  logic [7:0]  chan_req = '0;
  logic [23:0] chan_cause = '0;
  logic        chain_in = 1'b0;
  logic        chain_out;
  logic        rd_start = 1'b0;
  logic [15:0] rd_data;
  logic        rd_drive;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_line = '0;
  logic [7:0]  irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_arb_card dut_i (.*);

  // {card, chain_in, req, expected word, expected drive}
  // cause of channel p is 7-p in these rows
  localparam logic [28:0] VEC [8] = '{
    {3'd0, 1'b0, 8'h01, 16'h81C0, 1'b1},  // R1 R2 R3 port 0
    {3'd2, 1'b0, 8'h80, 16'h8017, 1'b1},  // R1 lowest port alone
    {3'd5, 1'b0, 8'hA4, 16'h816A, 1'b1},  // R1 mixed
    {3'd7, 1'b1, 8'hFF, 16'h0000, 1'b0},  // R6 blocked by chain
    {3'd3, 1'b0, 8'h00, 16'h0000, 1'b0},  // R6 nothing pending
    {3'd1, 1'b0, 8'h18, 16'h810B, 1'b1},
    {3'd4, 1'b0, 8'h60, 16'h80A5, 1'b1},
    {3'd6, 1'b0, 8'hFE, 16'h81B1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_start = 1'b1;
    @(negedge clk) rd_start = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++) chan_cause[p*3 +: 3] = 3'(7 - p);
    repeat (3) @(negedge clk);
    check("R10 rd_data", 32'(rd_data), 32'h0);
    check("R10 rd_drive", 32'(rd_drive), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chan_req = 8'h04;
    @(negedge clk);
    check("R10 line 0 after reset", 32'(irq_n), 32'hFE);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      card_id  = VEC[i][28:26];
      chain_in = VEC[i][25];
      chan_req = VEC[i][24:17];
      do_read();
      check("R1/R2/R3/R4/R6 word", 32'(rd_data), 32'(VEC[i][16:1]));
      check("R6 drive", 32'(rd_drive), 32'(VEC[i][0]));
      check("R5 chain_out", 32'(chain_out), 32'(VEC[i][25] | (VEC[i][24:17] != 0)));
      check("R8 lines", 32'(irq_n), (VEC[i][24:17] != 0) ? 32'hFE : 32'hFF);
    end

    // R2 with other causes
    chan_cause = 24'h0;
    chan_cause[4*3 +: 3] = 3'd3;
    card_id = 3'd1; chain_in = 1'b0; chan_req = 8'h30;
    do_read();
    check("R2 cause 3 port 4", 32'(rd_data), 32'h80CC);

    // R7 hold between reads
    chan_req = 8'h01;
    chan_cause = 24'hFFFFFF;
    card_id = 3'd7;
    repeat (3) @(negedge clk);
    check("R7 data held", 32'(rd_data), 32'h80CC);
    chain_in = 1'b1;
    @(negedge clk);
    check("R7 drive held", 32'(rd_drive), 32'h1);
    chain_in = 1'b0;

    // R9 line select, R8 release
    cfg_line = 3'd5; cfg_we = 1'b1;
    @(negedge clk) cfg_we = 1'b0; cfg_line = 3'd2;
    check("R9 line 5 selected", 32'(irq_n), 32'hDF);
    @(negedge clk);
    check("R9 no write without enable", 32'(irq_n), 32'hDF);
    chan_req = 8'h00;
    @(negedge clk);
    check("R8 released", 32'(irq_n), 32'hFF);
    check("R5 chain idle", 32'(chain_out), 32'h0);
    do_read();
    check("R6 empty read", 32'(rd_data), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule